// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two two's-complement operands of `WIDTH` bits over several clock cycles. It uses radix-2 Booth recoding. On an accepted start pulse it captures the multiplicand and the multiplier. It then runs one recode-add-shift step per clock for exactly `WIDTH` clocks. Finally it presents the full `2*WIDTH`-bit signed product together with a single-cycle completion pulse.

Each step looks at the lowest multiplier bit and the extension bit to its right. From that pair it adds the multiplicand to the accumulator, subtracts it, or leaves the accumulator alone. Then it shifts the chain accumulator / multiplier / extension right by one place, copying the sign bit. The accumulator carries one guard bit above `WIDTH`, so the most negative multiplicand cannot corrupt the sign. The surrounding logic holds `start` for one cycle with stable operands and waits for `done`. While `busy` is high, a new `start` is ignored.

Top module: `booth_seq_mult`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` sampled high at a clock edge where `busy` is low captures `mcand` and `mplier`, and `busy` is 1 after that same edge.
- R3: If a start is accepted at edge k, `done` is 1 after edge k+WIDTH and `busy` is 0 from that edge on. `busy` stays 1 after edges k through k+WIDTH-1.
- R4: `product` equals the signed product of the captured operands, as a `2*WIDTH`-bit two's-complement value, for every operand pair. The upper half comes from the accumulator and the lower half from the multiplier register.
- R5: With WIDTH=4, multiplicand 4'b0011 and multiplier 4'b1011 yield product 8'b11110001 (-15).
- R6: The most negative value on either operand gives the correct product. For example, -8 x -8 = 64 and -8 x 7 = -56 at WIDTH=4. The accumulator keeps one guard bit, and any carry above that bit is dropped.
- R7: `done` is high for exactly one cycle per accepted start.
- R8: A `start` sampled while `busy` is high has no effect. The running result is unchanged and no extra `done` pulse appears.
- R9: `product` changes only at the edge that raises `done`, and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication when idle |
| mcand | input | WIDTH | Multiplicand, two's complement |
| mplier | input | WIDTH | Multiplier, two's complement |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse: product is valid |
| product | output | 2*WIDTH | Signed product, registered |

## Verification
A wrong step count shows up straight away in the cycle of `done`. A pulse one clock early or late is caught on the very result it affects. A recoding fault, a sign-extension fault or a lost guard bit only shows as a wrong `product` value at the next `done`. The test therefore sweeps every operand pair at WIDTH=4, including both extremes, so that every bit-pair sequence appears. A start that leaks through while busy shows either as a corrupted product at the pending `done` or as an unexpected extra `done` pulse. Each of these is visible within WIDTH+1 cycles of the disturbance.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [1:0] {
    BOP_HOLD = 2'd0,
    BOP_ADD  = 2'd1,
    BOP_SUB  = 2'd2
  } booth_op_e;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic      q_lsb,
  input  logic      q_ext,
  output booth_op_e op
);

  // pair {q_lsb, q_ext}: 01 -> add, 10 -> subtract, 00/11 -> shift only
  always_comb begin
    case ({q_lsb, q_ext})
      2'b01:   op = BOP_ADD;
      2'b10:   op = BOP_SUB;
      default: op = BOP_HOLD;
    endcase
  end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic [AW-1:0] acc,
  input  logic [AW-1:0] addend,
  input  booth_op_e     op,
  output logic [AW-1:0] result
);

  logic [AW-1:0] operand;
  logic          carry_in;

  // shared adder: subtraction uses inverted operand and carry-in
  always_comb begin
    operand  = '0;
    carry_in = 1'b0;
    case (op)
      BOP_ADD: operand = addend;
      BOP_SUB: begin
        operand  = ~addend;
        carry_in = 1'b1;
      end
      default: operand = '0;
    endcase
    result = acc + operand + {{(AW-1){1'b0}}, carry_in};
  end

endmodule

// File: rtl/booth_step_ctr.sv
module booth_step_ctr #(
  parameter int STEPS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic advance,
  output logic last
);

  localparam int CW = $clog2(STEPS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CW'(STEPS);
    end else if (advance) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == CW'(1));

  // R3
  step_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(STEPS));

  // R3
  no_idle_step_chk: assert property (@(posedge clk) disable iff (rst)
    advance |-> cnt_q != '0);

endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               advance,
  input  logic [WIDTH-1:0]   mcand_in,
  input  logic [WIDTH-1:0]   mplier_in,
  output logic [2*WIDTH-1:0] prod_next
);

  localparam int AW = WIDTH + 1;

  logic [AW-1:0]    m_q;
  logic [AW-1:0]    a_q;
  logic [WIDTH-1:0] q_q;
  logic             x_q;

  booth_op_e        op;
  logic [AW-1:0]    sum;
  logic [AW-1:0]    a_sh;
  logic [WIDTH-1:0] q_sh;
  logic             x_sh;

  booth_recoder u_rec (
    .q_lsb (q_q[0]),
    .q_ext (x_q),
    .op    (op)
  );

  booth_addsub #(.AW(AW)) u_add (
    .acc    (a_q),
    .addend (m_q),
    .op     (op),
    .result (sum)
  );

  // arithmetic right shift across {A, Q, Q-1}
  always_comb begin
    a_sh = {sum[AW-1], sum[AW-1:1]};
    q_sh = {sum[0], q_q[WIDTH-1:1]};
    x_sh = q_q[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q <= '0;
      a_q <= '0;
      q_q <= '0;
      x_q <= 1'b0;
    end else if (load) begin
      m_q <= {mcand_in[WIDTH-1], mcand_in};
      a_q <= '0;
      q_q <= mplier_in;
      x_q <= 1'b0;
    end else if (advance) begin
      a_q <= a_sh;
      q_q <= q_sh;
      x_q <= x_sh;
    end
  end

  assign prod_next = {a_sh[WIDTH-1:0], q_sh};

  // R6
  a_headroom_chk: assert property (@(posedge clk) disable iff (rst)
    a_q[AW-1] == a_q[AW-2]);

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);

  localparam int PW = 2 * WIDTH;

  logic          busy_q;
  logic          done_q;
  logic [PW-1:0] prod_q;
  logic          load;
  logic          advance;
  logic          last;
  logic [PW-1:0] prod_next;

  assign load    = start && !busy_q;
  assign advance = busy_q;

  booth_step_ctr #(.STEPS(WIDTH)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .advance (advance),
    .last    (last)
  );

  booth_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .advance   (advance),
    .mcand_in  (mcand),
    .mplier_in (mplier),
    .prod_next (prod_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      prod_q <= '0;
    end else begin
      done_q <= busy_q && last;
      if (load) begin
        busy_q <= 1'b1;
      end else if (busy_q && last) begin
        busy_q <= 1'b0;
      end
      if (busy_q && last) begin
        prod_q <= prod_next;
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign product = prod_q;

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  busy_ends_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));

  // R9
  product_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(product));

endmodule

// File: tb/booth_seq_mult_test.sv
module booth_seq_mult_test;

  localparam int W  = 4;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  mcand = '0;
  logic [W-1:0]  mplier = '0;
  logic          busy;
  logic          done;
  logic [PW-1:0] product;

  int checks   = 0;
  int failures = 0;

  logic [PW-1:0] exp_q[$];
  string         tag_q[$];
  logic [PW-1:0] held = '0;

  always #4 clk = ~clk;

  booth_seq_mult #(.WIDTH(W)) uut (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .mcand   (mcand),
    .mplier  (mplier),
    .busy    (busy),
    .done    (done),
    .product (product)
  );

  function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [PW-1:0] sa;
    logic signed [PW-1:0] sb;
    sa = PW'($signed(a));
    sb = PW'($signed(b));
    return sa * sb;
  endfunction

  task automatic check(input bit ok, input string req, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each completion pulse
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (done) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R8 unexpected done", {{(PW-1){1'b0}}, done}, '0);
          end else begin
            logic [PW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(product == e, t, product, e);
          end
          held = product;
        end else begin
          check(product == held, "R9 product hold", product, held);
        end
      end
    end
  end

  // driver: issue one multiplication, optionally with starts while busy
  task automatic do_mul(input logic [W-1:0] mc, input logic [W-1:0] mp,
                        input string tag, input bit junk, input bit timed);
    int cyc;
    @(negedge clk);
    while (busy) @(negedge clk);
    mcand  = mc;
    mplier = mp;
    start  = 1'b1;
    exp_q.push_back(ref_mul(mc, mp));
    tag_q.push_back(tag);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", {{(PW-1){1'b0}}, busy}, 1);
    cyc = 1;
    if (junk) begin
      mcand  = ~mc;
      mplier = mp + 1'b1;
      start  = 1'b1;
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
      cyc = 3;
    end
    if (timed) begin
      while (!done) begin
        check(busy == 1'b1, "R3 busy during run", {{(PW-1){1'b0}}, busy}, 1);
        @(negedge clk);
        cyc++;
      end
      check(cyc == W + 1, "R3 done latency", PW'(cyc), PW'(W + 1));
      check(busy == 1'b0, "R3 busy low at done", {{(PW-1){1'b0}}, busy}, 0);
      @(negedge clk);
      check(done == 1'b0, "R7 done one cycle", {{(PW-1){1'b0}}, done}, 0);
    end
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while held in reset
    check(busy == 1'b0 && done == 1'b0, "R1 flags in reset", {busy, done}, 0);
    check(product == '0, "R1 product in reset", product, 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && product == '0, "R1 after reset", product, 0);

    // R5: worked example 3 x -5
    do_mul(4'b0011, 4'b1011, "R5 3x-5", 1'b0, 1'b1);
    check(held == 8'b1111_0001, "R5 result value", held, 8'b1111_0001);

    // R6: extreme operands
    do_mul(4'b1000, 4'b1000, "R6 -8x-8", 1'b0, 1'b1);
    do_mul(4'b1000, 4'b0111, "R6 -8x7", 1'b0, 1'b0);
    do_mul(4'b0111, 4'b1000, "R6 7x-8", 1'b0, 1'b0);
    do_mul(4'b1000, 4'b1111, "R6 -8x-1", 1'b0, 1'b1);

    // R8: start pulses while busy must not disturb the result
    do_mul(4'b0101, 4'b1101, "R8 start while busy", 1'b1, 1'b0);
    do_mul(4'b1010, 4'b0110, "R8 start while busy", 1'b1, 1'b0);

    // R4: every operand pair, back to back
    for (int ia = 0; ia < 16; ia++) begin
      for (int ib = 0; ib < 16; ib++) begin
        do_mul(4'(ia), 4'(ib), "R4 exhaustive", 1'b0, 1'b0);
      end
    end

    @(negedge clk);
    while (busy || exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R8 scoreboard drained", PW'(exp_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule